// File: doc/BRIEF.md
# Clock Stop and Output Gating Controller

This block sits between the clock dividers and the output pads of a system clock generator. It receives every divided clock as an ungated level signal that changes in step with a fast reference clock `clk`. It hands each one on to its pad, or parks it. The CPU group answers to an active-low CPU stop input and the PCI group to an active-low PCI stop input. An active-low power-down input parks everything. Each output also has its own enable bit, taken from configuration register bytes held elsewhere in the same clock domain.

Every output has a one-bit gate flop. That flop may change only while its source clock is low, so a pulse that has started always runs to its natural end, and a pulse that starts after a gate opens has full width. The stop and power-down inputs are asynchronous and pass through a synchronizer first. One CPU output and one PCI output are free-running. The CPU one ignores the CPU stop. The PCI one obeys the PCI stop only when a configuration bit marks it as stoppable. The last PCI output can run at the normal PCI rate or at twice that rate. The source switch also happens only when both candidate sources are low. Each DDR output is a true/complement pair. When it is parked, the true side is low and the complement side is high.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every single-ended output and every `ddr_t` bit is 0 and every `ddr_c` bit is 1. After reset, with all enables at 1, all stop inputs at 1 and `pwrdn_n` at 1, every output follows its source.
- R2: With `cpu_stop_n` at 0, every `cpu_clk` bit parks at 0, while `cpu_free_clk` keeps following its source.
- R3: With `pci_stop_n` at 0, every `pci_clk` bit parks at 0. `pci_free_clk` parks as well if `pci_free_stoppable` is 1, and keeps running if it is 0.
- R4: An enable bit at 0 parks only its own output at 0, and an enable bit at 1 lets it run. The stop and power-down conditions still apply on top of the enable bit.
- R5: With `pwrdn_n` at 0, every output parks, including both free-running outputs and the APIC, 48 MHz and reference outputs. Each `ddr_t` bit goes to 0 and each `ddr_c` bit goes to 1. Every park or release takes effect within SYNC_STAGES + 1 cycles plus the time the source spends high.
- R6: `ddr_c` is always the inverse of `ddr_t`. Neither stop input affects the DDR pairs.
- R7: The last PCI output follows the normal-rate PCI source when `pci_rate_base` is 1 and the double-rate source when it is 0. The switch is made only while both sources are low.
- R8: There are no runt pulses. Every rising edge of an output coincides with a rising edge of its source, and an output is never high while its source is low.
- R9: The AGP, APIC, 48 MHz and reference outputs ignore both stop inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock shared with the dividers |
| rst_n | input | 1 | Synchronous active-low reset |
| src_cpu | input | NUM_CPU | Ungated stoppable CPU clocks |
| src_cpu_free | input | 1 | Ungated free-running CPU clock |
| src_pci | input | NUM_PCI | Ungated PCI clocks at the normal rate |
| src_pci_dbl | input | 1 | Ungated double-rate PCI clock for the selectable output |
| src_pci_free | input | 1 | Ungated free-running PCI clock |
| src_agp | input | NUM_AGP | Ungated AGP clocks |
| src_ddr | input | NUM_DDR | Ungated DDR clocks (true phase) |
| src_apic | input | 1 | Ungated interrupt-controller clock |
| src_usb | input | 1 | Ungated 48 MHz clock |
| src_ref | input | 1 | Ungated crystal reference clock |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU group stop |
| pci_stop_n | input | 1 | Asynchronous active-low PCI group stop |
| pwrdn_n | input | 1 | Asynchronous active-low power-down |
| en_cpu | input | NUM_CPU | Enables for the stoppable CPU outputs (1 = run) |
| en_cpu_free | input | 1 | Enable for the free-running CPU output |
| en_pci | input | NUM_PCI | Enables for the PCI outputs |
| en_pci_free | input | 1 | Enable for the free-running PCI output |
| pci_free_stoppable | input | 1 | 1 = free-running PCI output obeys the PCI stop |
| pci_rate_base | input | 1 | Last PCI output rate: 1 = normal, 0 = double |
| en_agp | input | NUM_AGP | Enables for the AGP outputs |
| en_ddr | input | NUM_DDR | Enables for the DDR pairs |
| en_apic | input | 1 | Enable for the interrupt-controller clock |
| en_usb | input | 1 | Enable for the 48 MHz clock |
| en_ref | input | 1 | Enable for the reference clock |
| cpu_clk | output | NUM_CPU | Gated stoppable CPU clocks |
| cpu_free_clk | output | 1 | Gated free-running CPU clock |
| pci_clk | output | NUM_PCI | Gated PCI clocks |
| pci_free_clk | output | 1 | Gated free-running PCI clock |
| agp_clk | output | NUM_AGP | Gated AGP clocks |
| ddr_t | output | NUM_DDR | DDR pair true outputs |
| ddr_c | output | NUM_DDR | DDR pair complement outputs |
| apic_clk | output | 1 | Gated interrupt-controller clock |
| usb_clk | output | 1 | Gated 48 MHz clock |
| ref_clk | output | 1 | Gated reference clock |

## Verification
A gate flop in the wrong state shows at the pads at the next rising edge of its source. A clock either goes missing, or keeps toggling while its group is stopped. So a steady-state comparison against the source over a short window catches it within one source period. A gate or rate-select flop that updates while its source is high shows at once as a pulse that is cut short or that starts without a source edge. The bench watches every sample for that. A synchronizer that is stuck or wired to the wrong group parks the wrong set of outputs. That is visible as soon as the stop inputs are driven one at a time.

// File: rtl/clkgate_pkg.sv
// Shared types for the clock stop and gating controller.
// Assumes all sources are level signals in the clk domain.
package clkgate_pkg;

    // Rate choice for the selectable PCI output
    typedef enum logic {
        RATE_DOUBLE = 1'b0,
        RATE_BASE   = 1'b1
    } pci_rate_e;

    // Synchronized group controls, 1 = group may run
    typedef struct packed {
        logic pwr_ok;
        logic pci_go;
        logic cpu_go;
    } grp_ctl_t;

endpackage

// File: rtl/cg_sync.sv
// Multi-flop synchronizer for asynchronous control levels.
// Assumes inputs are quasi-static levels; reset value is a parameter.
module cg_sync #(
    parameter int                 STAGES  = 2,
    parameter int                 WIDTH   = 3,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    // Shift the asynchronous levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
        end else begin
            pipe_q[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/cg_rate_mux.sv
// Glitch-free two-source selector for the rate-selectable PCI output.
// Assumes both sources are level signals in the clk domain that share
// cycles where both are low; the select only moves in such a cycle.
module cg_rate_mux
    import clkgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic base_clk,
    input  logic dbl_clk,
    input  logic sel_base,
    output logic out_clk
);

    pci_rate_e sel_q;

    // Take the new rate only while both candidate sources are low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= RATE_BASE;
        end else if (!base_clk && !dbl_clk) begin
            sel_q <= pci_rate_e'(sel_base);
        end
    end

    // Route the chosen source
    always_comb begin
        out_clk = (sel_q == RATE_BASE) ? base_clk : dbl_clk;
    end

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_clk || dbl_clk) |=> $stable(sel_q));

endmodule

// File: rtl/cg_gate_bank.sv
// Bank of per-output clock gates. Each gate flop samples its run
// request only while its source is low, so outputs never carry a
// shortened high pulse. Assumes sources are level signals in clk domain.
module cg_gate_bank #(
    parameter int WIDTH = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] run,
    output logic [WIDTH-1:0] gated
);

    logic [WIDTH-1:0] gate_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
        // Update this gate only in the low phase of its source
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gate_q[i] <= 1'b0;
            end else if (!src[i]) begin
                gate_q[i] <= run[i];
            end
        end

        assign gated[i] = src[i] & gate_q[i];

        // R8
        gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            src[i] |=> (gate_q[i] == $past(gate_q[i])));

        // R8
        out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gated[i]) |-> $rose(src[i]));

        // R8
        out_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gated[i]) |-> $fell(src[i]));
    end

endmodule

// File: rtl/clk_stop_gate.sv
// Clock stop and output gating controller. Combines synchronized stop
// and power-down levels with per-output enables, selects the rate of the
// last PCI output, and gates every divided clock glitch-free.
// Assumes NUM_PCI >= 2 and all sources are level signals in clk domain.
module clk_stop_gate
    import clkgate_pkg::*;
#(
    parameter int NUM_CPU     = 2,
    parameter int NUM_PCI     = 7,
    parameter int NUM_AGP     = 2,
    parameter int NUM_DDR     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] src_cpu,
    input  logic               src_cpu_free,
    input  logic [NUM_PCI-1:0] src_pci,
    input  logic               src_pci_dbl,
    input  logic               src_pci_free,
    input  logic [NUM_AGP-1:0] src_agp,
    input  logic [NUM_DDR-1:0] src_ddr,
    input  logic               src_apic,
    input  logic               src_usb,
    input  logic               src_ref,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               pwrdn_n,
    input  logic [NUM_CPU-1:0] en_cpu,
    input  logic               en_cpu_free,
    input  logic [NUM_PCI-1:0] en_pci,
    input  logic               en_pci_free,
    input  logic               pci_free_stoppable,
    input  logic               pci_rate_base,
    input  logic [NUM_AGP-1:0] en_agp,
    input  logic [NUM_DDR-1:0] en_ddr,
    input  logic               en_apic,
    input  logic               en_usb,
    input  logic               en_ref,
    output logic [NUM_CPU-1:0] cpu_clk,
    output logic               cpu_free_clk,
    output logic [NUM_PCI-1:0] pci_clk,
    output logic               pci_free_clk,
    output logic [NUM_AGP-1:0] agp_clk,
    output logic [NUM_DDR-1:0] ddr_t,
    output logic [NUM_DDR-1:0] ddr_c,
    output logic               apic_clk,
    output logic               usb_clk,
    output logic               ref_clk
);

    localparam int OFS_CPUF = NUM_CPU;
    localparam int OFS_PCI  = OFS_CPUF + 1;
    localparam int OFS_PCIF = OFS_PCI + NUM_PCI;
    localparam int OFS_AGP  = OFS_PCIF + 1;
    localparam int OFS_DDR  = OFS_AGP + NUM_AGP;
    localparam int OFS_APIC = OFS_DDR + NUM_DDR;
    localparam int OFS_USB  = OFS_APIC + 1;
    localparam int OFS_REF  = OFS_USB + 1;
    localparam int TOTAL    = OFS_REF + 1;
    localparam int RATE_IDX = NUM_PCI - 1;

    grp_ctl_t           ctl;
    logic               rate_clk;
    logic [NUM_PCI-1:0] pci_src;
    logic [TOTAL-1:0]   src_all;
    logic [TOTAL-1:0]   run_all;
    logic [TOTAL-1:0]   gated_all;

    // Bring the asynchronous stop and power-down levels into clk domain
    cg_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (3),
        .RST_VAL (3'b000)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pwrdn_n, pci_stop_n, cpu_stop_n}),
        .dout  (ctl)
    );

    // Pick normal or double rate for the last PCI output
    cg_rate_mux u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_clk (src_pci[RATE_IDX]),
        .dbl_clk  (src_pci_dbl),
        .sel_base (pci_rate_base),
        .out_clk  (rate_clk)
    );

    // Substitute the rate-selected source into the PCI group
    always_comb begin
        pci_src           = src_pci;
        pci_src[RATE_IDX] = rate_clk;
    end

    // Flatten all sources in one fixed order
    always_comb begin
        src_all = {src_ref, src_usb, src_apic, src_ddr, src_agp,
                   src_pci_free, pci_src, src_cpu_free, src_cpu};
    end

    // Run request per output: enable, group stop and power-down combined
    always_comb begin
        run_all[OFS_CPUF-1:0]      = en_cpu & {NUM_CPU{ctl.pwr_ok & ctl.cpu_go}};
        run_all[OFS_CPUF]          = en_cpu_free & ctl.pwr_ok;
        run_all[OFS_PCIF-1:OFS_PCI] = en_pci & {NUM_PCI{ctl.pwr_ok & ctl.pci_go}};
        run_all[OFS_PCIF]          = en_pci_free & ctl.pwr_ok &
                                     (ctl.pci_go | ~pci_free_stoppable);
        run_all[OFS_DDR-1:OFS_AGP] = en_agp & {NUM_AGP{ctl.pwr_ok}};
        run_all[OFS_APIC-1:OFS_DDR] = en_ddr & {NUM_DDR{ctl.pwr_ok}};
        run_all[OFS_APIC]          = en_apic & ctl.pwr_ok;
        run_all[OFS_USB]           = en_usb & ctl.pwr_ok;
        run_all[OFS_REF]           = en_ref & ctl.pwr_ok;
    end

    // Glitch-free gate for every output
    cg_gate_bank #(
        .WIDTH (TOTAL)
    ) u_gates (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_all),
        .run   (run_all),
        .gated (gated_all)
    );

    // Split the gated vector onto the output ports
    always_comb begin
        cpu_clk      = gated_all[OFS_CPUF-1:0];
        cpu_free_clk = gated_all[OFS_CPUF];
        pci_clk      = gated_all[OFS_PCIF-1:OFS_PCI];
        pci_free_clk = gated_all[OFS_PCIF];
        agp_clk      = gated_all[OFS_DDR-1:OFS_AGP];
        ddr_t        = gated_all[OFS_APIC-1:OFS_DDR];
        ddr_c        = ~gated_all[OFS_APIC-1:OFS_DDR];
        apic_clk     = gated_all[OFS_APIC];
        usb_clk      = gated_all[OFS_USB];
        ref_clk      = gated_all[OFS_REF];
    end

    // R5
    pd_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ctl.pwr_ok) && $past(!src_ref)) |-> !ref_clk);

endmodule

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;

    localparam int NV = 23;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    int   checks = 0;
    int   failures = 0;

    // Sources, driven 2 ns after each rising edge
    int unsigned tcnt = 0;
    logic [1:0] s_cpu = '0;
    logic       s_cpuf = 1'b0;
    logic [6:0] s_pci = '0;
    logic       s_dbl = 1'b0;
    logic       s_pcif = 1'b0;
    logic [1:0] s_agp = '0;
    logic [6:0] s_ddr = '0;
    logic       s_apic = 1'b0, s_usb = 1'b0, s_ref = 1'b0;

    // Controls
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
    logic stoppable = 1'b1, rate_base = 1'b1;
    logic [NV-1:0] en_all = '1;

    logic [1:0] cpu_clk;
    logic       cpu_free_clk;
    logic [6:0] pci_clk;
    logic       pci_free_clk;
    logic [1:0] agp_clk;
    logic [6:0] ddr_t, ddr_c;
    logic       apic_clk, usb_clk, ref_clk;

    clk_stop_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .src_cpu(s_cpu), .src_cpu_free(s_cpuf), .src_pci(s_pci),
        .src_pci_dbl(s_dbl), .src_pci_free(s_pcif), .src_agp(s_agp),
        .src_ddr(s_ddr), .src_apic(s_apic), .src_usb(s_usb), .src_ref(s_ref),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
        .en_cpu(en_all[1:0]), .en_cpu_free(en_all[2]), .en_pci(en_all[9:3]),
        .en_pci_free(en_all[10]), .pci_free_stoppable(stoppable),
        .pci_rate_base(rate_base), .en_agp(en_all[12:11]),
        .en_ddr(en_all[19:13]), .en_apic(en_all[20]), .en_usb(en_all[21]),
        .en_ref(en_all[22]),
        .cpu_clk(cpu_clk), .cpu_free_clk(cpu_free_clk), .pci_clk(pci_clk),
        .pci_free_clk(pci_free_clk), .agp_clk(agp_clk), .ddr_t(ddr_t),
        .ddr_c(ddr_c), .apic_clk(apic_clk), .usb_clk(usb_clk), .ref_clk(ref_clk)
    );

    // Source waveforms: periods 4, 8, 6 and 14 cycles
    always @(posedge clk) begin
        #2;
        tcnt   = tcnt + 1;
        s_cpu  = {2{tcnt[1]}};
        s_cpuf = tcnt[1];
        s_pci  = {7{tcnt[2]}};
        s_dbl  = tcnt[1];
        s_pcif = tcnt[2];
        s_agp  = {2{tcnt[1]}};
        s_ddr  = {7{tcnt[1]}};
        s_apic = tcnt[2];
        s_usb  = (tcnt % 6) < 3;
        s_ref  = (tcnt % 14) < 7;
    end

    function automatic logic [NV-1:0] pack_out();
        return {ref_clk, usb_clk, apic_clk, ddr_t, agp_clk, pci_free_clk,
                pci_clk, cpu_free_clk, cpu_clk};
    endfunction

    // Expected outputs from the requirements
    function automatic logic [NV-1:0] exp_out();
        logic pd = pwrdn_n;
        logic cg = pwrdn_n & cpu_stop_n;
        logic pg = pwrdn_n & pci_stop_n;
        logic [NV-1:0] s, run;
        s = {s_ref, s_usb, s_apic, s_ddr, s_agp, s_pcif,
             (rate_base ? s_pci[6] : s_dbl), s_pci[5:0], s_cpuf, s_cpu};
        run = {{12{pd}}, pd & (pci_stop_n | ~stoppable), {7{pg}}, pd, {2{cg}}};
        return s & run & en_all;
    endfunction

    function automatic logic [NV-1:0] runt_src();
        return {s_ref, s_usb, s_apic, s_ddr, s_agp, s_pcif,
                s_pci[6] | s_dbl, s_pci[5:0], s_cpuf, s_cpu};
    endfunction

    task automatic check(input string req, input logic [NV-1:0] act,
                         input logic [NV-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // R8 / R6 monitor on every sample
    int runt_bad = 0;
    int cmp_bad = 0;
    logic [NV-1:0] prev_o = '0, prev_s = '0;
    logic prev_b6 = 1'b0, prev_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NV-1:0] cur, sv;
            cur = pack_out();
            sv  = runt_src();
            for (int b = 0; b < NV; b++) begin
                logic rose_src;
                rose_src = (b == 9) ? ((s_pci[6] & ~prev_b6) | (s_dbl & ~prev_d))
                                    : (sv[b] & ~prev_s[b]);
                if (cur[b] && !sv[b]) runt_bad++;
                if (cur[b] && !prev_o[b] && !rose_src) runt_bad++;
            end
            if (ddr_c !== ~ddr_t) cmp_bad++;
            prev_o  = cur;
            prev_s  = sv;
            prev_b6 = s_pci[6];
            prev_d  = s_dbl;
        end
    end

    // Settle, then compare every sample of a window
    task automatic steady(input string req);
        int bad = 0;
        logic [NV-1:0] fa = '0, fe = '0;
        repeat (16) @(posedge clk);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (pack_out() !== exp_out() && bad == 0) begin
                fa = pack_out();
                fe = exp_out();
            end
            if (pack_out() !== exp_out()) bad++;
        end
        if (bad == 0) check(req, '0, '0);
        else          check(req, fa, fe);
    endtask

    task automatic count_rises(input int idx, input int n, output int r);
        logic p;
        r = 0;
        @(negedge clk);
        p = pack_out()[idx];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pack_out()[idx] && !p) r++;
            p = pack_out()[idx];
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd4711));

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 reset outputs", pack_out(), '0);
        check("R1 reset ddr_c", {16'd0, ddr_c}, {16'd0, 7'h7f});
        @(posedge clk); #1 rst_n = 1'b1;
        steady("R1 all running");

        // R2: CPU stop, free CPU output keeps running
        cpu_stop_n = 1'b0;
        steady("R2 cpu stop");
        count_rises(2, 16, r);
        check("R2 free cpu rises", NV'(r), NV'(4));

        // R3: PCI stop, free PCI output not stoppable
        pci_stop_n = 1'b0; stoppable = 1'b0;
        steady("R3 pci stop free runs");
        count_rises(10, 16, r);
        check("R3 free pci rises", NV'(r), NV'(2));
        stoppable = 1'b1;
        steady("R3 pci stop free stopped");

        // R9 and R6: both stops low, other groups and DDR still run
        steady("R9 R6 stops do not touch others");
        count_rises(22, 28, r);
        check("R9 ref rises", NV'(r), NV'(2));
        count_rises(13, 16, r);
        check("R6 ddr rises under stops", NV'(r), NV'(4));

        // R5: power-down parks everything
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwrdn_n = 1'b0;
        steady("R5 power-down");
        @(negedge clk);
        check("R5 pd outputs", pack_out(), '0);
        check("R5 pd ddr_c", {16'd0, ddr_c}, {16'd0, 7'h7f});
        pwrdn_n = 1'b1;
        steady("R5 release");

        // R4: walk a single zero through the enables
        for (int i = 0; i < NV; i++) begin
            en_all = ~(NV'(1) << i);
            steady("R4 single disable");
        end
        en_all = '1;

        // R7: rate select
        rate_base = 1'b0;
        repeat (16) @(posedge clk);
        count_rises(9, 32, r);
        check("R7 double rate rises", NV'(r), NV'(8));
        rate_base = 1'b1;
        repeat (16) @(posedge clk);
        count_rises(9, 32, r);
        check("R7 base rate rises", NV'(r), NV'(4));

        // Random mix over R2 R3 R4 R5 R7 R9
        for (int n = 0; n < 40; n++) begin
            en_all     = ~(NV'($urandom) & NV'($urandom) & NV'($urandom));
            cpu_stop_n = ($urandom % 4) != 0;
            pci_stop_n = ($urandom % 4) != 0;
            pwrdn_n    = ($urandom % 8) != 0;
            stoppable  = $urandom % 2;
            rate_base  = $urandom % 2;
            steady("R4 R5 random mix");
        end

        check("R8 no runt pulses", NV'(runt_bad), '0);
        check("R6 complement", NV'(cmp_bad), '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule